// File: doc/BRIEF.md
# Multi-Mode Program Bank Mapper

This block turns a 16-bit console CPU address into a physical address for program ROM or work RAM. Software sets it up by writing to a small control window in the 0x5xxx range. One register holds a 2-bit mode. Five registers hold bank numbers: one picks the work-RAM bank and four serve the ROM windows. The mode sets how the 32 KB space from 0x8000 to 0xFFFF is cut into windows:

- one 32 KB window;
- two 16 KB windows;
- one 16 KB window followed by two 8 KB windows;
- four 8 KB windows.

Each mode ignores a different number of low bits in the bank registers it uses.

The address path is combinational from the CPU address and the registered state. A write to a control register takes effect on the clock edge where it is strobed, so the next access already uses the new mapping. ROM size is a power-of-two parameter, and the ROM offset wraps by masking to that size. The 8 KB window at 0x6000–0x7FFF maps into work RAM through a 3-bit bank number.

Top module: `prg_bank_mapper`

## Requirements
- R1: After reset the mode is four 8 KB windows. The four ROM window registers hold bank numbers NB-4, NB-3, NB-2 and NB-1, where NB is the ROM size divided by 8 KB. The RAM bank is 0.
- R2: A write to 0x5100 loads the mode from data bits 1:0 and ignores the upper data bits. The modes are 0 = 32 KB, 1 = 16+16, 2 = 16+8+8, 3 = 8x4.
- R3: For an address in 0x6000–0x7FFF, `hit_ram` is 1 and `out_addr` is {bank, cpu_addr[12:0]}. The bank is bits 2:0 of the value last written to 0x5113.
- R4: In mode 0, the 8 KB bank for window w (w = cpu_addr[14:13]) is {bits 6:2 of 0x5117, w}.
- R5: In mode 1, window w uses {bits 6:1 of 0x5115, w[0]} when w is below 2, and {bits 6:1 of 0x5117, w[0]} otherwise.
- R6: In mode 2:
  - windows 0 and 1 use {bits 6:1 of 0x5115, w[0]};
  - window 2 uses bits 6:0 of 0x5116;
  - window 3 uses bits 6:0 of 0x5117.
- R7: In mode 3, windows 0 to 3 use bits 6:0 of 0x5114, 0x5115, 0x5116 and 0x5117 in that order.
- R8: The ROM address is (bank × 8 KB + cpu_addr[12:0]) modulo the ROM size. The low 13 bits always equal cpu_addr[12:0].
- R9: Writes to any address other than 0x5100 and 0x5113–0x5117 leave the mapping unchanged. This includes 0x5101, 0x5112, 0x5118 and the ROM space. A register write is visible from the cycle after its clock edge.
- R10: `hit_rom` is 1 exactly when cpu_addr[15] is 1. When neither flag is set, `out_addr` is 0. The two flags are never both 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 16 | CPU address |
| cpu_data | input | 8 | CPU write data |
| cpu_wr | input | 1 | CPU write strobe, sampled on the rising clock edge |
| out_addr | output | OUT_W (17 by default) | Physical ROM or RAM address |
| hit_rom | output | 1 | Address falls in the ROM space |
| hit_ram | output | 1 | Address falls in the work-RAM window |

## Verification
The bench sets up distinct bank values and walks every window in every mode.

- A swap in which register feeds which window shows up as a wrong bank at 0xA000 or 0xC000.
- A wrong number of dropped low bits makes mode 0 or mode 1 land on an odd bank where an even one is expected.
- Bank 0x7F checks the wrap on a 128 KB ROM. A design without the mask would drive address bits above the ROM size.
- Writes to neighbouring addresses (0x5101, 0x5112, 0x5118 and the ROM space) check the address decode. A loose decode would move the mode or a window.
- A second reset checks that the default last-four-banks layout comes back.

// File: rtl/prg_map_pkg.sv
package prg_map_pkg;
    localparam int CPU_AW    = 16;
    localparam int CPU_DW    = 8;
    localparam int WIN_OFS_W = 13;   // 8 KB window offset
    localparam int BANK_W    = 7;    // ROM bank register width in use
    localparam int RAM_SEL_W = 3;    // work-RAM bank select width
    localparam int ROM_WINS  = 4;

    localparam logic [CPU_AW-1:0] MODE_REG_ADDR = 16'h5100;
    localparam logic [CPU_AW-1:0] RAM_REG_ADDR  = 16'h5113;
    localparam logic [CPU_AW-1:0] ROM_REG_BASE  = 16'h5114;

    typedef enum logic [1:0] {
        MAP_32K    = 2'd0,
        MAP_16_16  = 2'd1,
        MAP_16_8_8 = 2'd2,
        MAP_8X4    = 2'd3
    } map_mode_e;

    typedef struct packed {
        map_mode_e                              mode;
        logic [RAM_SEL_W-1:0]                   ram_bank;
        logic [ROM_WINS-1:0][BANK_W-1:0]        rom_bank;
    } map_state_t;
endpackage

// File: rtl/prg_bank_regs.sv
module prg_bank_regs
    import prg_map_pkg::*;
#(
    parameter int ROM_AW = 17
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [CPU_AW-1:0]  cpu_addr,
    input  logic [CPU_DW-1:0]  cpu_data,
    input  logic               cpu_wr,
    output map_state_t         state
);
    localparam int NUM_BANKS = 1 << (ROM_AW - WIN_OFS_W);

    map_state_t st_d, st_q;
    logic       unused_data;

    assign unused_data = cpu_data[CPU_DW-1];

    always_comb begin
        st_d = st_q;
        if (cpu_wr) begin
            if (cpu_addr == MODE_REG_ADDR)
                st_d.mode = map_mode_e'(cpu_data[1:0]);
            if (cpu_addr == RAM_REG_ADDR)
                st_d.ram_bank = cpu_data[RAM_SEL_W-1:0];
            for (int i = 0; i < ROM_WINS; i++) begin
                if (cpu_addr == ROM_REG_BASE + CPU_AW'(i))
                    st_d.rom_bank[i] = cpu_data[BANK_W-1:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.mode     <= MAP_8X4;
            st_q.ram_bank <= '0;
            for (int i = 0; i < ROM_WINS; i++)
                st_q.rom_bank[i] <= BANK_W'(NUM_BANKS - ROM_WINS + i);
        end else begin
            st_q <= st_d;
        end
    end

    assign state = st_q;
endmodule

// File: rtl/prg_window_decode.sv
module prg_window_decode
    import prg_map_pkg::*;
(
    input  map_mode_e                        mode,
    input  logic [ROM_WINS-1:0][BANK_W-1:0]  rom_bank,
    input  logic [1:0]                       win,
    output logic [BANK_W-1:0]                bank8
);
    logic [BANK_W-1:0] r_lo16, r_b, r_c;

    assign r_lo16 = rom_bank[1];
    assign r_b    = rom_bank[2];
    assign r_c    = rom_bank[3];

    always_comb begin
        unique case (mode)
            MAP_32K:    bank8 = {r_c[BANK_W-1:2], win};
            MAP_16_16:  bank8 = win[1] ? {r_c[BANK_W-1:1], win[0]}
                                       : {r_lo16[BANK_W-1:1], win[0]};
            MAP_16_8_8: begin
                if (!win[1])     bank8 = {r_lo16[BANK_W-1:1], win[0]};
                else if (!win[0]) bank8 = r_b;
                else              bank8 = r_c;
            end
            default:    bank8 = rom_bank[win];
        endcase
    end
endmodule

// File: rtl/prg_addr_form.sv
module prg_addr_form
    import prg_map_pkg::*;
#(
    parameter int ROM_AW = 17,
    parameter int OUT_W  = 17
) (
    input  logic [CPU_AW-1:0]     cpu_addr,
    input  logic [BANK_W-1:0]     bank8,
    input  logic [RAM_SEL_W-1:0]  ram_bank,
    output logic [OUT_W-1:0]      out_addr,
    output logic                  hit_rom,
    output logic                  hit_ram
);
    localparam int FULL_W = BANK_W + WIN_OFS_W;
    localparam int RAM_AW = RAM_SEL_W + WIN_OFS_W;

    logic [FULL_W-1:0] rom_full;
    logic [ROM_AW-1:0] rom_wrapped;
    logic [RAM_AW-1:0] ram_full;
    logic              unused_hi;

    assign rom_full    = {bank8, cpu_addr[WIN_OFS_W-1:0]};
    assign rom_wrapped = rom_full[ROM_AW-1:0];   // power-of-two modulo
    assign ram_full    = {ram_bank, cpu_addr[WIN_OFS_W-1:0]};
    assign unused_hi   = ^rom_full[FULL_W-1:ROM_AW];

    always_comb begin
        hit_rom  = cpu_addr[CPU_AW-1];
        hit_ram  = (cpu_addr[CPU_AW-1:WIN_OFS_W] == 3'b011);
        out_addr = '0;
        if (hit_rom)      out_addr = OUT_W'(rom_wrapped);
        else if (hit_ram) out_addr = OUT_W'(ram_full);
    end
endmodule

// File: rtl/prg_bank_mapper.sv
module prg_bank_mapper
    import prg_map_pkg::*;
#(
    parameter int ROM_AW = 17,
    localparam int RAM_AW = RAM_SEL_W + WIN_OFS_W,
    localparam int OUT_W  = (ROM_AW > RAM_AW) ? ROM_AW : RAM_AW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [15:0]       cpu_addr,
    input  logic [7:0]        cpu_data,
    input  logic              cpu_wr,
    output logic [OUT_W-1:0]  out_addr,
    output logic              hit_rom,
    output logic              hit_ram
);
    map_state_t        st;
    logic [BANK_W-1:0] bank8;

    prg_bank_regs #(.ROM_AW(ROM_AW)) regs_i (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr),
        .cpu_data(cpu_data), .cpu_wr(cpu_wr), .state(st)
    );

    prg_window_decode dec_i (
        .mode(st.mode), .rom_bank(st.rom_bank),
        .win(cpu_addr[WIN_OFS_W+1:WIN_OFS_W]), .bank8(bank8)
    );

    prg_addr_form #(.ROM_AW(ROM_AW), .OUT_W(OUT_W)) form_i (
        .cpu_addr(cpu_addr), .bank8(bank8), .ram_bank(st.ram_bank),
        .out_addr(out_addr), .hit_rom(hit_rom), .hit_ram(hit_ram)
    );
endmodule

// File: rtl/prg_bank_mapper_chk.sv
module prg_bank_mapper_chk #(
    parameter int OUT_W = 17
) (
    input logic              clk,
    input logic              rst_n,
    input logic [15:0]       cpu_addr,
    input logic              cpu_wr,
    input logic [OUT_W-1:0]  out_addr,
    input logic              hit_rom,
    input logic              hit_ram
);
    assert_flags_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({hit_rom, hit_ram}));

    assert_idle_addr_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!hit_rom && !hit_ram) |-> (out_addr == '0));

    assert_ram_offset_R3: assert property (@(posedge clk) disable iff (!rst_n)
        hit_ram |-> (out_addr[12:0] == cpu_addr[12:0]));

    assert_rom_offset_R8: assert property (@(posedge clk) disable iff (!rst_n)
        hit_rom |-> (out_addr[12:0] == cpu_addr[12:0]));

    assert_hold_without_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!cpu_wr) && $stable(cpu_addr)) |-> $stable(out_addr));
endmodule

bind prg_bank_mapper prg_bank_mapper_chk #(.OUT_W(OUT_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wr(cpu_wr),
    .out_addr(out_addr), .hit_rom(hit_rom), .hit_ram(hit_ram)
);

// File: tb/prg_bank_mapper_tb_top.sv
module prg_bank_mapper_tb_top;
    localparam int ROM_AW = 17;
    localparam int OUT_W  = 17;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [15:0]       cpu_addr = '0;
    logic [7:0]        cpu_data = '0;
    logic              cpu_wr = 1'b0;
    logic [OUT_W-1:0]  out_addr;
    logic              hit_rom, hit_ram;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;   // 50 MHz

    prg_bank_mapper #(.ROM_AW(ROM_AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_data(cpu_data),
        .cpu_wr(cpu_wr), .out_addr(out_addr), .hit_rom(hit_rom), .hit_ram(hit_ram)
    );

    function automatic logic [OUT_W-1:0] rom_exp(input int bank, input logic [15:0] a);
        logic [31:0] full;
        full = (32'(bank) << 13) | 32'(a[12:0]);
        return OUT_W'(full & ((32'd1 << ROM_AW) - 1));
    endfunction

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0; cpu_wr = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk); cpu_addr = a; cpu_data = d; cpu_wr = 1'b1;
        @(negedge clk); cpu_wr = 1'b0;
    endtask

    task automatic look(input string req, input logic [15:0] a,
                        input logic [OUT_W-1:0] exp_addr, input logic exp_rom,
                        input logic exp_ram);
        @(negedge clk); cpu_addr = a;
        #3;
        checks++;
        if (out_addr !== exp_addr || hit_rom !== exp_rom || hit_ram !== exp_ram) begin
            errors++;
            $display("FAIL %s addr=%h: got out=%h rom=%b ram=%b, expected out=%h rom=%b ram=%b",
                     req, a, out_addr, hit_rom, hit_ram, exp_addr, exp_rom, exp_ram);
        end
    endtask

    task automatic t_reset_defaults();   // R1, R10
        look("R1", 16'h8000, rom_exp(12, 16'h8000), 1, 0);
        look("R1", 16'hA123, rom_exp(13, 16'hA123), 1, 0);
        look("R1", 16'hC000, rom_exp(14, 16'hC000), 1, 0);
        look("R1", 16'hFFFF, rom_exp(15, 16'hFFFF), 1, 0);
        look("R1", 16'h6000, '0, 0, 1);
        look("R10", 16'h5000, '0, 0, 0);
    endtask

    task automatic t_mode3();   // R7, R8
        wr(16'h5114, 8'h03);
        wr(16'h5115, 8'h05);
        wr(16'h5116, 8'h7F);
        wr(16'h5117, 8'h01);
        look("R7", 16'h8010, rom_exp(3, 16'h8010), 1, 0);
        look("R7", 16'hA000, rom_exp(5, 16'hA000), 1, 0);
        look("R8", 16'hC004, 17'h1E004, 1, 0);
        look("R7", 16'hE000, rom_exp(1, 16'hE000), 1, 0);
    endtask

    task automatic t_mode0();   // R2, R4
        wr(16'h5117, 8'h09);
        wr(16'h5100, 8'hFC);   // upper bits ignored, mode 0
        look("R4", 16'h8000, rom_exp(8, 16'h8000), 1, 0);
        look("R4", 16'hA000, rom_exp(9, 16'hA000), 1, 0);
        look("R2", 16'hE010, rom_exp(11, 16'hE010), 1, 0);
    endtask

    task automatic t_mode1();   // R5
        wr(16'h5100, 8'h01);
        look("R5", 16'h8000, rom_exp(4, 16'h8000), 1, 0);
        look("R5", 16'hA000, rom_exp(5, 16'hA000), 1, 0);
        look("R5", 16'hC000, rom_exp(8, 16'hC000), 1, 0);
        look("R5", 16'hE001, rom_exp(9, 16'hE001), 1, 0);
    endtask

    task automatic t_mode2();   // R6, R8
        wr(16'h5100, 8'h02);
        look("R6", 16'h8000, rom_exp(4, 16'h8000), 1, 0);
        look("R6", 16'hA000, rom_exp(5, 16'hA000), 1, 0);
        look("R6", 16'hC000, 17'h1E000, 1, 0);
        look("R6", 16'hE000, rom_exp(9, 16'hE000), 1, 0);
    endtask

    task automatic t_ignored_writes();   // R9
        wr(16'h5118, 8'h00);
        wr(16'h5112, 8'h00);
        wr(16'h5101, 8'h03);
        wr(16'h9000, 8'h00);
        look("R9", 16'hC000, 17'h1E000, 1, 0);
        look("R9", 16'hE000, rom_exp(9, 16'hE000), 1, 0);
        look("R9", 16'h8000, rom_exp(4, 16'h8000), 1, 0);
        look("R9", 16'h6000, '0, 0, 1);
    endtask

    task automatic t_ram();   // R3
        wr(16'h5113, 8'hFE);
        look("R3", 16'h6ABC, 17'h0CABC, 0, 1);
        look("R3", 16'h7FFF, 17'h0DFFF, 0, 1);
        look("R10", 16'h4020, '0, 0, 0);
    endtask

    task automatic t_rereset();   // R1
        do_reset();
        look("R1", 16'h8000, rom_exp(12, 16'h8000), 1, 0);
        look("R1", 16'hE000, rom_exp(15, 16'hE000), 1, 0);
        look("R1", 16'h6100, 17'h00100, 0, 1);
    endtask

    initial begin
        do_reset();
        t_reset_defaults();
        t_mode3();
        t_mode0();
        t_mode1();
        t_mode2();
        t_ignored_writes();
        t_ram();
        t_rereset();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #2_000_000;
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule